// File: doc/BRIEF.md
# Five-Stage In-Order Integer Pipeline

This block executes a small 32-bit load/store instruction set through five stages: fetch, decode, execute, memory access and writeback. Each instruction's operands, control bits and destination register number travel with it through four pipeline registers. A separate hazard unit forwards results from the two older in-flight instructions into the execute stage. When an instruction needs a value that a load immediately ahead of it has not yet fetched, the hazard unit inserts one bubble. The program counter moves forward one word per cycle and never branches.

Instruction memory and data memory are small internal word arrays. While reset is held, a preload port writes into either array. Once reset is released, the pipeline starts at word 0. Two debug outputs let an observer read the block's state: a flat view of all 32 architectural registers, and a count of the instructions that have left writeback.

Top module: `pipe_core`

## Requirements
- R1: While `rst` is high, all registers read zero, the retired count is zero and no instruction is in flight. The preload port writes `ld_data` into instruction memory (`ld_sel`=0) or data memory (`ld_sel`=1) at word `ld_addr`, but only while `rst` is high. A preload attempted while running has no effect.
- R2: Instruction fields are opcode [31:26], rs [25:21], rt [20:16], rd [15:11] and imm [15:0]. Opcode 0x00 with funct 0x20, 0x22, 0x24 or 0x25 writes rs+rt, rs-rt, rs&rt or rs|rt (modulo 2^32) into rd.
- R3: Opcode 0x00 with funct 0x2A writes 1 into rd when rs < rt as signed values, and 0 otherwise.
- R4: Opcode 0x23 writes into rt the data word at word index (rs + sign-extended imm)[DM_AW+1:2].
- R5: Opcode 0x2B writes the rt value into that data word. A later load of the same word returns it.
- R6: Register 0 always reads zero. An instruction that targets register 0 changes nothing, and its result is never forwarded.
- R7: An instruction reading a register written by either of the two instructions ahead of it gets the new value without inserted no-ops. When both of those instructions write the register, the nearer one wins, including for store data.
- R8: A consumer directly behind a load stalls for exactly one cycle. The program counter holds during the stall and the consumer still sees the loaded value. K cycles after reset release, the retired count equals K-4 minus the number of bubbles.
- R9: Writeback uses the destination number that travelled with the instruction: rd for register-register operations and rt for loads. It never uses the number of the instruction currently in decode.
- R10: The all-zero word, and any unsupported encoding, writes no register and no memory word. Every fetched instruction, no-ops included, adds one to the retired count as it leaves writeback. Bubbles add nothing.
- R11: A register written back in a cycle is seen by an instruction decoding that register in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high; also enables preloading |
| ld_en | input | 1 | Preload write strobe |
| ld_sel | input | 1 | Preload target: 0 instruction memory, 1 data memory |
| ld_addr | input | LD_AW | Preload word index |
| ld_data | input | 32 | Preload word |
| dbg_regs | output | 32*32 | Register n on bits [32n+31:32n] |
| dbg_retired | output | RET_W | Instructions that have left writeback |

## Verification
The checker watches four things on every cycle: register 0 stays at zero, the retired count grows exactly with the valid flag leaving writeback, a stall freezes the program counter and injects a bubble, and destination numbers move stage to stage unchanged. Forwarding priority, signed comparison, store-then-load ordering, write-through in the register file and the ignored preload during operation are visible only in the final register values. The bench's programs establish those values.

// File: rtl/pipe_pkg.sv
package pipe_pkg;
   localparam int XLEN   = 32;
   localparam int NREGS  = 32;
   localparam int RIDX_W = 5;

   localparam logic [5:0] OP_RTYPE = 6'h00;
   localparam logic [5:0] OP_LOAD  = 6'h23;
   localparam logic [5:0] OP_STORE = 6'h2B;

   localparam logic [5:0] FN_ADD = 6'h20;
   localparam logic [5:0] FN_SUB = 6'h22;
   localparam logic [5:0] FN_AND = 6'h24;
   localparam logic [5:0] FN_OR  = 6'h25;
   localparam logic [5:0] FN_SLT = 6'h2A;

   // operand source selects for the execute stage
   localparam logic [1:0] SRC_REG = 2'b00;
   localparam logic [1:0] SRC_MEM = 2'b10;
   localparam logic [1:0] SRC_WB  = 2'b01;

   typedef enum logic [2:0] {
      ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_SLT
   } alu_op_e;

   typedef struct packed {
      logic    reg_write;
      logic    mem_to_reg;
      logic    mem_write;
      logic    imm_sel;
      logic    dst_is_rd;
      logic    reads_rt;
      alu_op_e alu_op;
   } ctrl_t;
endpackage

// File: rtl/pipe_decode.sv
module pipe_decode
   import pipe_pkg::*;
(
   input  logic [5:0] opcode,
   input  logic [5:0] funct,
   output ctrl_t      ctrl
);
   always_comb begin
      ctrl = '0;
      ctrl.alu_op = ALU_ADD;
      unique case (opcode)
         OP_RTYPE: begin
            ctrl.dst_is_rd = 1'b1;
            ctrl.reads_rt  = 1'b1;
            ctrl.reg_write = 1'b1;
            case (funct)
               FN_ADD:  ctrl.alu_op = ALU_ADD;
               FN_SUB:  ctrl.alu_op = ALU_SUB;
               FN_AND:  ctrl.alu_op = ALU_AND;
               FN_OR:   ctrl.alu_op = ALU_OR;
               FN_SLT:  ctrl.alu_op = ALU_SLT;
               default: ctrl = '0;
            endcase
         end
         OP_LOAD: begin
            ctrl.reg_write  = 1'b1;
            ctrl.mem_to_reg = 1'b1;
            ctrl.imm_sel    = 1'b1;
         end
         OP_STORE: begin
            ctrl.mem_write = 1'b1;
            ctrl.imm_sel   = 1'b1;
            ctrl.reads_rt  = 1'b1;
         end
         default: ctrl = '0;
      endcase
   end
endmodule

// File: rtl/pipe_regfile.sv
module pipe_regfile
   import pipe_pkg::*;
#(
   parameter bit WR_THRU = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst,
   input  logic                   we,
   input  logic [RIDX_W-1:0]      waddr,
   input  logic [XLEN-1:0]        wdata,
   input  logic [RIDX_W-1:0]      raddr_a,
   input  logic [RIDX_W-1:0]      raddr_b,
   output logic [XLEN-1:0]        rdata_a,
   output logic [XLEN-1:0]        rdata_b,
   output logic [NREGS*XLEN-1:0]  dbg
);
   logic [XLEN-1:0] regs [NREGS];

   for (genvar i = 0; i < NREGS; i++) begin : g_reg
      if (i == 0) begin : g_zero
         assign regs[i] = '0;
      end else begin : g_flop
         logic [XLEN-1:0] q;
         always_ff @(posedge clk) begin
            if (rst)                                 q <= '0;
            else if (we && waddr == RIDX_W'(i))      q <= wdata;
         end
         assign regs[i] = q;
      end
      assign dbg[i*XLEN +: XLEN] = regs[i];
   end

   if (WR_THRU) begin : g_thru
      assign rdata_a = (we && waddr == raddr_a && raddr_a != '0) ? wdata : regs[raddr_a];
      assign rdata_b = (we && waddr == raddr_b && raddr_b != '0) ? wdata : regs[raddr_b];
   end else begin : g_plain
      assign rdata_a = regs[raddr_a];
      assign rdata_b = regs[raddr_b];
   end
endmodule

// File: rtl/pipe_alu.sv
module pipe_alu
   import pipe_pkg::*;
(
   input  logic [XLEN-1:0] a,
   input  logic [XLEN-1:0] b,
   input  alu_op_e         op,
   output logic [XLEN-1:0] y
);
   always_comb begin
      y = '0;
      unique case (op)
         ALU_ADD: y = a + b;
         ALU_SUB: y = a - b;
         ALU_AND: y = a & b;
         ALU_OR:  y = a | b;
         ALU_SLT: y[0] = $signed(a) < $signed(b);
         default: y = '0;
      endcase
   end
endmodule

// File: rtl/pipe_hazard.sv
module pipe_hazard
   import pipe_pkg::*;
(
   input  logic [RIDX_W-1:0] id_rs,
   input  logic [RIDX_W-1:0] id_rt,
   input  logic              id_reads_rt,
   input  logic              ex_load,
   input  logic [RIDX_W-1:0] ex_dst,
   input  logic [RIDX_W-1:0] ex_rs,
   input  logic [RIDX_W-1:0] ex_rt,
   input  logic              mem_regw,
   input  logic [RIDX_W-1:0] mem_dst,
   input  logic              wb_regw,
   input  logic [RIDX_W-1:0] wb_dst,
   output logic              stall,
   output logic [1:0]        src_a,
   output logic [1:0]        src_b
);
   function automatic logic [1:0] pick(input logic [RIDX_W-1:0] r,
                                       input logic mw, input logic [RIDX_W-1:0] md,
                                       input logic ww, input logic [RIDX_W-1:0] wd);
      if (mw && md != '0 && md == r)      return SRC_MEM;
      else if (ww && wd != '0 && wd == r) return SRC_WB;
      else                                return SRC_REG;
   endfunction

   assign src_a = pick(ex_rs, mem_regw, mem_dst, wb_regw, wb_dst);
   assign src_b = pick(ex_rt, mem_regw, mem_dst, wb_regw, wb_dst);

   assign stall = ex_load && ex_dst != '0 &&
                  (ex_dst == id_rs || (id_reads_rt && ex_dst == id_rt));
endmodule

// File: rtl/pipe_core.sv
module pipe_core
   import pipe_pkg::*;
#(
   parameter int IMEM_DEPTH = 64,
   parameter int DMEM_DEPTH = 64,
   parameter int RET_W      = 16,
   parameter int LD_AW      = (IMEM_DEPTH > DMEM_DEPTH) ? $clog2(IMEM_DEPTH) : $clog2(DMEM_DEPTH)
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  ld_en,
   input  logic                  ld_sel,
   input  logic [LD_AW-1:0]      ld_addr,
   input  logic [XLEN-1:0]       ld_data,
   output logic [NREGS*XLEN-1:0] dbg_regs,
   output logic [RET_W-1:0]      dbg_retired
);
   localparam int IM_AW = $clog2(IMEM_DEPTH);
   localparam int DM_AW = $clog2(DMEM_DEPTH);

   if (IMEM_DEPTH < 2 || (IMEM_DEPTH & (IMEM_DEPTH - 1)) != 0) begin : g_bad_im
      $error("IMEM_DEPTH must be a power of two of at least 2");
   end
   if (DMEM_DEPTH < 2 || (DMEM_DEPTH & (DMEM_DEPTH - 1)) != 0 || DM_AW > 29) begin : g_bad_dm
      $error("DMEM_DEPTH must be a power of two between 2 and 2^29");
   end
   if (RET_W < 1 || LD_AW < IM_AW || LD_AW < DM_AW) begin : g_bad_w
      $error("RET_W or LD_AW too small");
   end

   logic [XLEN-1:0] imem [IMEM_DEPTH];
   logic [XLEN-1:0] dmem [DMEM_DEPTH];

   // ---------------- fetch ----------------
   logic [IM_AW-1:0] pc_q;
   logic [XLEN-1:0]  d_instr;
   logic             d_valid;
   logic             hz_stall;

   always_ff @(posedge clk) begin
      if (rst && ld_en && !ld_sel) imem[ld_addr[IM_AW-1:0]] <= ld_data;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         pc_q    <= '0;
         d_instr <= '0;
         d_valid <= 1'b0;
      end else if (!hz_stall) begin
         pc_q    <= pc_q + IM_AW'(1);
         d_instr <= imem[pc_q];
         d_valid <= 1'b1;
      end
   end

   // ---------------- decode ----------------
   ctrl_t             id_ctrl;
   logic [RIDX_W-1:0] id_rs, id_rt, id_rd, id_dst;
   logic [XLEN-1:0]   id_rsv, id_rtv, id_imm;

   assign id_rs  = d_instr[25:21];
   assign id_rt  = d_instr[20:16];
   assign id_rd  = d_instr[15:11];
   assign id_imm = {{(XLEN-16){d_instr[15]}}, d_instr[15:0]};

   pipe_decode u_dec (.opcode(d_instr[31:26]), .funct(d_instr[5:0]), .ctrl(id_ctrl));

   assign id_dst = id_ctrl.dst_is_rd ? id_rd : id_rt;

   logic              w_regw;
   logic [RIDX_W-1:0] w_dst;
   logic [XLEN-1:0]   wb_data;

   pipe_regfile #(.WR_THRU(1'b1)) u_rf (
      .clk(clk), .rst(rst),
      .we(w_regw), .waddr(w_dst), .wdata(wb_data),
      .raddr_a(id_rs), .raddr_b(id_rt),
      .rdata_a(id_rsv), .rdata_b(id_rtv),
      .dbg(dbg_regs)
   );

   // ---------------- ID/EX ----------------
   logic              x_valid, x_regw, x_m2r, x_memw, x_imm_sel;
   alu_op_e           x_op;
   logic [XLEN-1:0]   x_rsv, x_rtv, x_imm;
   logic [RIDX_W-1:0] x_rs, x_rt, x_dst;

   always_ff @(posedge clk) begin
      if (rst || hz_stall) begin
         x_valid   <= 1'b0;
         x_regw    <= 1'b0;
         x_m2r     <= 1'b0;
         x_memw    <= 1'b0;
         x_imm_sel <= 1'b0;
         x_op      <= ALU_ADD;
         x_rsv     <= '0;
         x_rtv     <= '0;
         x_imm     <= '0;
         x_rs      <= '0;
         x_rt      <= '0;
         x_dst     <= '0;
      end else begin
         x_valid   <= d_valid;
         x_regw    <= id_ctrl.reg_write;
         x_m2r     <= id_ctrl.mem_to_reg;
         x_memw    <= id_ctrl.mem_write;
         x_imm_sel <= id_ctrl.imm_sel;
         x_op      <= id_ctrl.alu_op;
         x_rsv     <= id_rsv;
         x_rtv     <= id_rtv;
         x_imm     <= id_imm;
         x_rs      <= id_rs;
         x_rt      <= id_rt;
         x_dst     <= id_dst;
      end
   end

   // ---------------- execute ----------------
   logic              m_valid, m_regw, m_m2r, m_memw;
   logic [XLEN-1:0]   m_alu, m_st;
   logic [RIDX_W-1:0] m_dst;
   logic [1:0]        src_a, src_b;
   logic [XLEN-1:0]   ex_a, ex_b_reg, ex_b, ex_y;

   pipe_hazard u_hz (
      .id_rs(id_rs), .id_rt(id_rt), .id_reads_rt(id_ctrl.reads_rt),
      .ex_load(x_m2r), .ex_dst(x_dst), .ex_rs(x_rs), .ex_rt(x_rt),
      .mem_regw(m_regw), .mem_dst(m_dst),
      .wb_regw(w_regw), .wb_dst(w_dst),
      .stall(hz_stall), .src_a(src_a), .src_b(src_b)
   );

   always_comb begin
      unique case (src_a)
         SRC_MEM: ex_a = m_alu;
         SRC_WB:  ex_a = wb_data;
         default: ex_a = x_rsv;
      endcase
      unique case (src_b)
         SRC_MEM: ex_b_reg = m_alu;
         SRC_WB:  ex_b_reg = wb_data;
         default: ex_b_reg = x_rtv;
      endcase
      ex_b = x_imm_sel ? x_imm : ex_b_reg;
   end

   pipe_alu u_alu (.a(ex_a), .b(ex_b), .op(x_op), .y(ex_y));

   // ---------------- EX/MEM ----------------
   always_ff @(posedge clk) begin
      if (rst) begin
         m_valid <= 1'b0;
         m_regw  <= 1'b0;
         m_m2r   <= 1'b0;
         m_memw  <= 1'b0;
         m_alu   <= '0;
         m_st    <= '0;
         m_dst   <= '0;
      end else begin
         m_valid <= x_valid;
         m_regw  <= x_regw;
         m_m2r   <= x_m2r;
         m_memw  <= x_memw;
         m_alu   <= ex_y;
         m_st    <= ex_b_reg;
         m_dst   <= x_dst;
      end
   end

   // ---------------- memory ----------------
   logic [DM_AW-1:0] m_widx;
   logic [XLEN-1:0]  m_rdata;

   assign m_widx  = m_alu[DM_AW+1:2];
   assign m_rdata = dmem[m_widx];

   always_ff @(posedge clk) begin
      if (rst) begin
         if (ld_en && ld_sel) dmem[ld_addr[DM_AW-1:0]] <= ld_data;
      end else if (m_valid && m_memw) begin
         dmem[m_widx] <= m_st;
      end
   end

   // ---------------- MEM/WB ----------------
   logic            w_valid, w_m2r;
   logic [XLEN-1:0] w_alu, w_rd;

   always_ff @(posedge clk) begin
      if (rst) begin
         w_valid <= 1'b0;
         w_regw  <= 1'b0;
         w_m2r   <= 1'b0;
         w_alu   <= '0;
         w_rd    <= '0;
         w_dst   <= '0;
      end else begin
         w_valid <= m_valid;
         w_regw  <= m_regw;
         w_m2r   <= m_m2r;
         w_alu   <= m_alu;
         w_rd    <= m_rdata;
         w_dst   <= m_dst;
      end
   end

   assign wb_data = w_m2r ? w_rd : w_alu;

   // ---------------- retirement ----------------
   logic [RET_W-1:0] ret_q;

   always_ff @(posedge clk) begin
      if (rst)          ret_q <= '0;
      else if (w_valid) ret_q <= ret_q + RET_W'(1);
   end

   assign dbg_retired = ret_q;
endmodule

// File: rtl/pipe_core_chk.sv
module pipe_core_chk
   import pipe_pkg::*;
#(
   parameter int IM_AW = 6,
   parameter int RET_W = 16
) (
   input logic              clk,
   input logic              rst,
   input logic              stall,
   input logic [IM_AW-1:0]  pc,
   input logic              x_valid,
   input logic [RIDX_W-1:0] m_dst,
   input logic [RIDX_W-1:0] w_dst,
   input logic              w_regw,
   input logic              w_valid,
   input logic [XLEN-1:0]   reg0,
   input logic [RET_W-1:0]  retired
);
   // R1
   reset_count_chk: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> retired == '0);

   // R6
   zero_reg_chk: assert property (@(posedge clk) disable iff (rst)
      (w_regw && w_dst == '0) |=> reg0 == '0);

   // R8
   stall_pc_chk: assert property (@(posedge clk) disable iff (rst)
      stall |=> pc == $past(pc));

   // R8
   stall_bubble_chk: assert property (@(posedge clk) disable iff (rst)
      stall |=> !x_valid);

   // R9
   dst_carry_chk: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> w_dst == $past(m_dst));

   // R10
   retire_step_chk: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> retired == $past(retired) + RET_W'($past(w_valid)));
endmodule

bind pipe_core pipe_core_chk #(.IM_AW(IM_AW), .RET_W(RET_W)) u_chk (
   .clk(clk), .rst(rst), .stall(hz_stall), .pc(pc_q), .x_valid(x_valid),
   .m_dst(m_dst), .w_dst(w_dst), .w_regw(w_regw), .w_valid(w_valid),
   .reg0(dbg_regs[31:0]), .retired(dbg_retired)
);

// File: tb/sim_pipe_core.sv
module sim_pipe_core;
   import pipe_pkg::*;

   localparam int IM_D  = 64;
   localparam int DM_D  = 64;
   localparam int RET_W = 16;
   localparam int LD_AW = 6;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic ld_en = 1'b0;
   logic ld_sel = 1'b0;
   logic [LD_AW-1:0] ld_addr = '0;
   logic [XLEN-1:0]  ld_data = '0;
   logic [NREGS*XLEN-1:0] dbg_regs;
   logic [RET_W-1:0]      dbg_retired;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   pipe_core #(.IMEM_DEPTH(IM_D), .DMEM_DEPTH(DM_D), .RET_W(RET_W), .LD_AW(LD_AW)) u0 (
      .clk(clk), .rst(rst), .ld_en(ld_en), .ld_sel(ld_sel), .ld_addr(ld_addr),
      .ld_data(ld_data), .dbg_regs(dbg_regs), .dbg_retired(dbg_retired)
   );

   function automatic logic [31:0] rw(input logic [5:0] fn, input int rd, input int rs, input int rt);
      return {OP_RTYPE, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
   endfunction

   function automatic logic [31:0] iw(input logic [5:0] op, input int rt, input int rs, input logic [15:0] imm);
      return {op, 5'(rs), 5'(rt), imm};
   endfunction

   localparam int NV = 28;
   // program rows: instruction, register to check at the end, expected value, requirement
   localparam logic [31:0] V_INSTR [NV] = '{
      iw(OP_LOAD, 1, 0, 16'd0),     // R4
      iw(OP_LOAD, 2, 0, 16'd4),     // R4
      iw(OP_LOAD, 3, 0, 16'd8),     // R4
      rw(FN_ADD, 4, 1, 2),          // R11 on rs, R7 on rt
      rw(FN_SUB, 5, 3, 1),          // R2
      rw(FN_SLT, 6, 3, 1),          // R3
      rw(FN_SLT, 7, 1, 3),          // R3
      rw(FN_AND, 8, 5, 1),          // R2
      rw(FN_OR, 9, 8, 3),           // R7
      rw(FN_ADD, 10, 9, 9),         // R7
      rw(FN_ADD, 11, 1, 1),
      rw(FN_ADD, 11, 11, 2),        // R9
      rw(FN_ADD, 12, 11, 11),       // R7 nearer writer wins
      iw(OP_STORE, 12, 0, 16'd20),  // R5
      iw(OP_LOAD, 13, 0, 16'd20),   // R5
      rw(FN_ADD, 0, 1, 1),          // R6
      rw(FN_ADD, 14, 0, 2),         // R6
      iw(OP_LOAD, 15, 4, 16'd4),    // R4
      iw(OP_LOAD, 16, 4, 16'd8),    // R4
      iw(OP_LOAD, 17, 4, 16'hFFF8), // R4
      iw(OP_LOAD, 18, 0, 16'd12),
      iw(OP_STORE, 18, 0, 16'd24),  // R8
      iw(OP_LOAD, 19, 0, 16'd24),   // R8
      32'h0000_0000,                // R10
      iw(OP_LOAD, 20, 0, 16'd16),
      rw(FN_AND, 21, 20, 3),        // R8
      rw(FN_OR, 22, 21, 1),         // R7
      rw(FN_SUB, 23, 1, 2)          // R2
   };
   localparam int V_REG [NV] = '{1, 2, 3, 4, 5, 6, 7, 8, 9, 10, 0, 11, 12, 0, 13, 0,
                                 14, 15, 16, 17, 18, 0, 19, 0, 20, 21, 22, 23};
   localparam logic [31:0] V_EXP [NV] = '{
      32'd5, 32'd3, 32'hFFFF_FFF0, 32'd8, 32'hFFFF_FFEB, 32'd1, 32'd0, 32'd1,
      32'hFFFF_FFF1, 32'hFFFF_FFE2, 32'd0, 32'd13, 32'd26, 32'd0, 32'd26, 32'd0,
      32'd3, 32'h1234_5678, 32'h0F0F_00FF, 32'd5, 32'h1234_5678, 32'd0,
      32'h1234_5678, 32'd0, 32'h0F0F_00FF, 32'h0F0F_00F0, 32'h0F0F_00F5, 32'd2
   };
   localparam int V_REQ [NV] = '{4, 4, 4, 11, 2, 3, 3, 2, 7, 7, 6, 9, 7, 5, 5, 6,
                                 6, 4, 4, 4, 4, 5, 8, 10, 4, 8, 7, 2};

   function automatic logic [31:0] dm_init(input int i);
      case (i)
         0:       return 32'd5;
         1:       return 32'd3;
         2:       return 32'hFFFF_FFF0;
         3:       return 32'h1234_5678;
         4:       return 32'h0F0F_00FF;
         default: return 32'd0;
      endcase
   endfunction

   function automatic logic [31:0] reg_of(input int i);
      return dbg_regs[i*XLEN +: XLEN];
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   task automatic load(input logic sel, input int addr, input logic [31:0] data);
      ld_en   = 1'b1;
      ld_sel  = sel;
      ld_addr = LD_AW'(addr);
      ld_data = data;
      @(posedge clk);
      @(negedge clk);
      ld_en   = 1'b0;
   endtask

   initial begin
      #2_000_000;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [31:0] acc;
      rst = 1'b1;
      repeat (2) @(negedge clk);

      // R1: reset state
      for (int i = 0; i < NREGS; i++) chk("R1", reg_of(i), 32'd0);
      chk("R1", 32'(dbg_retired), 32'd0);

      for (int i = 0; i < IM_D; i++) load(1'b0, i, (i < NV) ? V_INSTR[i] : 32'd0);
      for (int i = 0; i < DM_D; i++) load(1'b1, i, dm_init(i));

      // main program walked by the vector table
      rst = 1'b0;
      repeat (60) @(posedge clk);
      @(negedge clk);
      chk("R8", 32'(dbg_retired), 32'd54);  // 60 - 4 fill - 2 bubbles
      for (int v = 0; v < NV; v++)
         chk($sformatf("R%0d row %0d", V_REQ[v], v), reg_of(V_REG[v]), V_EXP[v]);
      chk("R6", reg_of(0), 32'd0);

      // directed: reset mid-run, then a no-op program
      rst = 1'b1;
      @(negedge clk);
      chk("R1", 32'(dbg_retired), 32'd0);
      chk("R1", reg_of(13), 32'd0);
      for (int i = 0; i < IM_D; i++) load(1'b0, i, 32'd0);
      rst = 1'b0;
      // R1: preload while running must be ignored (would load 5 into register 1)
      load(1'b0, 20, iw(OP_LOAD, 1, 0, 16'd0));
      repeat (39) @(posedge clk);
      @(negedge clk);
      chk("R10", 32'(dbg_retired), 32'd36);
      chk("R1", reg_of(1), 32'd0);
      acc = '0;
      for (int i = 0; i < NREGS; i++) acc |= reg_of(i);
      chk("R10", acc, 32'd0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule